// File: doc/BRIEF.md
# Burst Transmit Packet Framer

The framer builds the address and payload part of an outgoing radio packet while a host writes a serial burst. The host raises a select line and waits before sending its first bit. It then clocks bits in on a serial clock and data pair and lowers the select line once it has sent three trailing dummy bits. The framer brings these asynchronous host lines into the system clock domain and collects the bits into bytes. It writes one byte per cycle into a downstream transmit FIFO, where a modulator picks them up.

The framer takes a snapshot of its configuration when the select line rises. The destination address comes either from a five-byte register bank or from the first bytes the host sends, and a configuration bit picks which. An optional sender address is taken from a second five-byte bank. The sender address is always the same length as the destination address. The field order in the FIFO is destination, then sender, then payload. If the host sends more whole bytes than the burst limit allows, the framer drops the extra bytes and raises a sticky error flag. A done flag marks the end of each burst.

Top module: `burst_tx_framer`

## Requirements
- R1: When `cfg_dst_from_host` is 0, the framer writes L destination bytes from `cfg_dst_bank` before any host byte. Byte k of the bank is bits [8k+7:8k], and the bytes go out in the order k = L-1 down to 0.
- R2: When `cfg_dst_from_host` is 1, the first L whole host bytes are the destination address. The framer writes them in the order received (most significant first), and the payload bytes follow them.
- R3: When `cfg_src_en` is 1, the framer writes L sender bytes from `cfg_src_bank` right after the destination address, with the same byte order as R1. When `cfg_src_en` is 0, no sender bytes appear.
- R4: L is `cfg_addr_len` clamped to the range 1 to 5. A value of 0 gives 1, and a value of 6 or 7 gives 5.
- R5: The framer samples host bits on the rising edge of `host_sclk`, most significant bit first. It writes each host byte once its eighth bit has arrived.
- R6: The framer never writes a partial byte at the end of a burst, whether it holds the three dummy bits or up to seven bits. It discards those bits.
- R7: A burst may carry up to 37 whole host bytes (296 bits) without error. Each whole byte beyond that is dropped and sets `burst_ovf`. `burst_ovf` stays set until the next burst starts.
- R8: `burst_done` rises after `host_sel` falls. The next rise of `host_sel` clears both `burst_done` and `burst_ovf`.
- R9: The framer captures the configuration inputs at the rise of `host_sel`. Changes made to them during a burst have no effect on that burst.
- R10: After reset, `fifo_wr_en`, `burst_done` and `burst_ovf` are all 0.
- R11: Clock edges on `host_sclk` while `host_sel` is low write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| host_sel | input | 1 | Burst select from host, asynchronous |
| host_sclk | input | 1 | Host serial clock, asynchronous |
| host_sdat | input | 1 | Host serial data, asynchronous |
| cfg_dst_from_host | input | 1 | 1: destination address is sent in-band by the host |
| cfg_addr_len | input | 3 | Address length in bytes (clamped to 1..5) |
| cfg_src_en | input | 1 | Insert the sender address |
| cfg_dst_bank | input | 40 | Destination address register bank |
| cfg_src_bank | input | 40 | Sender address register bank |
| fifo_wr_en | output | 1 | FIFO write strobe, one byte per cycle |
| fifo_wr_data | output | 8 | FIFO write byte |
| burst_done | output | 1 | Burst finished |
| burst_ovf | output | 1 | Burst exceeded the host byte limit |

## Verification
Each host line passes through two synchronizer flops and one edge register. A host byte therefore reaches the FIFO port about four clock cycles after its eighth serial clock rises. Register-bank bytes start about four cycles after the select line rises, and the flags settle three to four cycles after a select edge. The bench records every write on the falling clock edge, so the order of the writes matters and not the cycle each one lands in. It samples the flags at least eight cycles after each select edge, well past these latencies. A sweep covers all eight length codes with both address sources and both sender settings. The expected byte stream is computed in the bench from the clamped length and the bank contents.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int unsigned ADDR_BYTES = 5;
  localparam int unsigned LEN_W      = 3;
  localparam int unsigned BANK_W     = ADDR_BYTES * 8;

  typedef enum logic [2:0] {
    S_IDLE, S_DST, S_HDST, S_SRC, S_PAY
  } seq_state_t;

  // Clamp a raw length code to the range 1..ADDR_BYTES.
  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
    if (raw == '0) return LEN_W'(1);
    if (int'(raw) > int'(ADDR_BYTES)) return LEN_W'(ADDR_BYTES);
    return raw;
  endfunction

  // Byte k of a bank sits at bits [8k+7:8k].
  function automatic logic [7:0] bank_byte(input logic [BANK_W-1:0] bank,
                                           input logic [LEN_W-1:0] k);
    int base;
    base = int'(k) * 8;
    return bank[base +: 8];
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] meta_q;

  for (genvar g = 0; g < W; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        lvl_o[g]  <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        lvl_o[g]  <= meta_q[g];
      end
    end
  end
endmodule

// File: rtl/bit_deser.sv
module bit_deser #(
  parameter int unsigned MAX_BYTES = 37
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       active_i,
  input  logic       bit_stb_i,
  input  logic       bit_i,
  output logic       byte_stb_o,
  output logic [7:0] byte_o,
  output logic       ovf_o
);
  localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1);

  logic [6:0]       sh_q;
  logic [2:0]       bit_cnt_q;
  logic [CNT_W-1:0] nbytes_q;
  logic             take_bit;
  logic             byte_done;
  logic             at_limit;
  logic [7:0]       next_byte;

  assign take_bit  = active_i && bit_stb_i;
  assign byte_done = take_bit && (bit_cnt_q == 3'd7);
  assign at_limit  = (nbytes_q == CNT_W'(MAX_BYTES));
  assign next_byte = {sh_q, bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      bit_cnt_q  <= '0;
      nbytes_q   <= '0;
      byte_stb_o <= 1'b0;
      byte_o     <= '0;
      ovf_o      <= 1'b0;
    end else begin
      byte_stb_o <= 1'b0;
      if (clear_i) begin
        sh_q      <= '0;
        bit_cnt_q <= '0;
        nbytes_q  <= '0;
        ovf_o     <= 1'b0;
      end else if (take_bit) begin
        sh_q      <= next_byte[6:0];
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (byte_done) begin
          if (at_limit) begin
            ovf_o <= 1'b1;
          end else begin
            byte_stb_o <= 1'b1;
            byte_o     <= next_byte;
            nbytes_q   <= nbytes_q + CNT_W'(1);
          end
        end
      end
    end
  end

  p_byte_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nbytes_q <= CNT_W'(MAX_BYTES));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clear_i) |=> ovf_o);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !byte_stb_o);
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import framer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              cfg_dst_host_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              cfg_src_en_i,
  input  logic [BANK_W-1:0] cfg_dst_i,
  input  logic [BANK_W-1:0] cfg_src_i,
  input  logic              byte_stb_i,
  input  logic [7:0]        byte_i,
  output logic              wr_en_o,
  output logic [7:0]        wr_data_o
);
  seq_state_t        st_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  idx_q;
  logic [LEN_W-1:0]  left_q;
  logic              src_en_q;
  logic [BANK_W-1:0] dst_q;
  logic [BANK_W-1:0] src_q;
  logic              hold_vld_q;
  logic [7:0]        hold_q;
  logic              consume;
  logic [LEN_W-1:0]  len_start;

  assign consume   = hold_vld_q && ((st_q == S_HDST) || (st_q == S_PAY));
  assign len_start = clamp_len(cfg_len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      len_q      <= LEN_W'(1);
      idx_q      <= '0;
      left_q     <= '0;
      src_en_q   <= 1'b0;
      dst_q      <= '0;
      src_q      <= '0;
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
      wr_en_o    <= 1'b0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (consume) hold_vld_q <= 1'b0;
      if (byte_stb_i) begin
        hold_vld_q <= 1'b1;
        hold_q     <= byte_i;
      end
      if (start_i) begin
        len_q      <= len_start;
        src_en_q   <= cfg_src_en_i;
        dst_q      <= cfg_dst_i;
        src_q      <= cfg_src_i;
        idx_q      <= len_start - LEN_W'(1);
        left_q     <= len_start;
        hold_vld_q <= 1'b0;
        st_q       <= cfg_dst_host_i ? S_HDST : S_DST;
      end else if (stop_i) begin
        st_q <= S_IDLE;
      end else begin
        case (st_q)
          S_DST: begin
            wr_en_o   <= 1'b1;
            wr_data_o <= bank_byte(dst_q, idx_q);
            if (idx_q == '0) begin
              idx_q <= len_q - LEN_W'(1);
              st_q  <= src_en_q ? S_SRC : S_PAY;
            end else begin
              idx_q <= idx_q - LEN_W'(1);
            end
          end
          S_SRC: begin
            wr_en_o   <= 1'b1;
            wr_data_o <= bank_byte(src_q, idx_q);
            if (idx_q == '0) st_q <= S_PAY;
            else idx_q <= idx_q - LEN_W'(1);
          end
          S_HDST: begin
            if (hold_vld_q) begin
              wr_en_o   <= 1'b1;
              wr_data_o <= hold_q;
              left_q    <= left_q - LEN_W'(1);
              if (left_q == LEN_W'(1)) begin
                idx_q <= len_q - LEN_W'(1);
                st_q  <= src_en_q ? S_SRC : S_PAY;
              end
            end
          end
          S_PAY: begin
            if (hold_vld_q) begin
              wr_en_o   <= 1'b1;
              wr_data_o <= hold_q;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  p_hold_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb_i |-> (!hold_vld_q || consume));
  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |-> (len_q >= LEN_W'(1) && int'(len_q) <= int'(ADDR_BYTES)));
  p_wr_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(st_q != S_IDLE));
endmodule

// File: rtl/burst_tx_framer.sv
module burst_tx_framer
  import framer_pkg::*;
#(
  parameter int unsigned HOST_BITS_MAX = 296
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_sclk,
  input  logic              host_sdat,
  input  logic              cfg_dst_from_host,
  input  logic [LEN_W-1:0]  cfg_addr_len,
  input  logic              cfg_src_en,
  input  logic [BANK_W-1:0] cfg_dst_bank,
  input  logic [BANK_W-1:0] cfg_src_bank,
  output logic              fifo_wr_en,
  output logic [7:0]        fifo_wr_data,
  output logic              burst_done,
  output logic              burst_ovf
);
  localparam int unsigned MAX_BYTES = HOST_BITS_MAX / 8;

  logic [2:0] sync_lvl;
  logic       sel_prev_q;
  logic       sclk_prev_q;
  logic       sel_lvl;
  logic       sclk_lvl;
  logic       sdat_lvl;
  logic       burst_start;
  logic       burst_stop;
  logic       sclk_rise;
  logic       byte_stb;
  logic [7:0] byte_val;

  hs_sync #(.W(3)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({host_sel, host_sdat, host_sclk}),
    .lvl_o   (sync_lvl)
  );

  assign sel_lvl     = sync_lvl[2];
  assign sdat_lvl    = sync_lvl[1];
  assign sclk_lvl    = sync_lvl[0];
  assign burst_start = sel_lvl && !sel_prev_q;
  assign burst_stop  = !sel_lvl && sel_prev_q;
  assign sclk_rise   = sclk_lvl && !sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q  <= 1'b0;
      sclk_prev_q <= 1'b0;
      burst_done  <= 1'b0;
    end else begin
      sel_prev_q  <= sel_lvl;
      sclk_prev_q <= sclk_lvl;
      if (burst_start) burst_done <= 1'b0;
      else if (burst_stop) burst_done <= 1'b1;
    end
  end

  bit_deser #(.MAX_BYTES(MAX_BYTES)) u_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (burst_start),
    .active_i   (sel_lvl),
    .bit_stb_i  (sclk_rise),
    .bit_i      (sdat_lvl),
    .byte_stb_o (byte_stb),
    .byte_o     (byte_val),
    .ovf_o      (burst_ovf)
  );

  frame_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (burst_start),
    .stop_i         (burst_stop),
    .cfg_dst_host_i (cfg_dst_from_host),
    .cfg_len_i      (cfg_addr_len),
    .cfg_src_en_i   (cfg_src_en),
    .cfg_dst_i      (cfg_dst_bank),
    .cfg_src_i      (cfg_src_bank),
    .byte_stb_i     (byte_stb),
    .byte_i         (byte_val),
    .wr_en_o        (fifo_wr_en),
    .wr_data_o      (fifo_wr_data)
  );

  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (!burst_done && !burst_ovf));
  p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_stop |=> burst_done);
  p_no_byte_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_lvl && !sel_prev_q) |=> !byte_stb);
endmodule

// File: tb/burst_tx_framer_test.sv
module burst_tx_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 37;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_sclk = 1'b0, host_sdat = 1'b0;
  logic        cfg_dst_from_host = 1'b0, cfg_src_en = 1'b0;
  logic [2:0]  cfg_addr_len = 3'd1;
  logic [39:0] cfg_dst_bank = '0, cfg_src_bank = '0;
  logic        fifo_wr_en, burst_done, burst_ovf;
  logic [7:0]  fifo_wr_data;

  int checks = 0, fails = 0, ncap = 0;
  logic [7:0] cap [0:127];
  logic [7:0] expb [0:127];
  logic [7:0] host_b [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_sclk(host_sclk),
    .host_sdat(host_sdat), .cfg_dst_from_host(cfg_dst_from_host),
    .cfg_addr_len(cfg_addr_len), .cfg_src_en(cfg_src_en),
    .cfg_dst_bank(cfg_dst_bank), .cfg_src_bank(cfg_src_bank),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .burst_done(burst_done), .burst_ovf(burst_ovf)
  );

  always @(negedge clk) begin
    if (rst_n && fifo_wr_en) begin
      if (ncap < 128) cap[ncap] = fifo_wr_data;
      ncap++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    host_sdat = b;
    repeat (4) @(posedge clk);
    host_sclk = 1'b1;
    repeat (8) @(posedge clk);
    host_sclk = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic run_burst(input bit dh, input logic [2:0] lr, input bit se,
                           input int nhost, input int tail, input bit mid,
                           input string req);
    int len, hb, ne, mism;
    len = (lr == 0) ? 1 : ((lr > 5) ? 5 : int'(lr));
    hb  = (nhost > MAXB) ? MAXB : nhost;
    ne  = 0;
    cfg_dst_from_host = dh; cfg_addr_len = lr; cfg_src_en = se;
    if (!dh) begin
      for (int k = len - 1; k >= 0; k--) begin expb[ne] = cfg_dst_bank[k*8 +: 8]; ne++; end
      if (se) for (int k = len - 1; k >= 0; k--) begin expb[ne] = cfg_src_bank[k*8 +: 8]; ne++; end
      for (int i = 0; i < hb; i++) begin expb[ne] = host_b[i]; ne++; end
    end else begin
      for (int i = 0; i < hb && i < len; i++) begin expb[ne] = host_b[i]; ne++; end
      if (se && hb >= len)
        for (int k = len - 1; k >= 0; k--) begin expb[ne] = cfg_src_bank[k*8 +: 8]; ne++; end
      for (int i = len; i < hb; i++) begin expb[ne] = host_b[i]; ne++; end
    end
    ncap = 0;
    host_sel = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(!burst_done && !burst_ovf, "R8 flags cleared at burst start",
        int'({burst_done, burst_ovf}), 0);
    if (mid) begin
      cfg_dst_bank = ~cfg_dst_bank; cfg_src_bank = ~cfg_src_bank;
      cfg_addr_len = 3'd5; cfg_src_en = ~se; cfg_dst_from_host = ~dh;
    end
    repeat (22) @(posedge clk);
    for (int i = 0; i < nhost; i++)
      for (int b = 7; b >= 0; b--) send_bit(host_b[i][b]);
    for (int t = 0; t < tail; t++) send_bit(t[0]);
    repeat (6) @(posedge clk);
    host_sel = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    mism = -1;
    for (int i = 0; i < ne && i < ncap; i++)
      if (mism < 0 && cap[i] !== expb[i]) mism = i;
    chk(ncap == ne, {req, " byte count"}, ncap, ne);
    if (mism >= 0)
      chk(1'b0, {req, " byte value"}, int'(cap[mism]), int'(expb[mism]));
    else
      chk(1'b1, req, 0, 0);
    chk(burst_done === 1'b1, "R8 done after select falls", int'(burst_done), 1);
    chk(burst_ovf === (nhost > MAXB), "R7 overflow flag", int'(burst_ovf), int'(nhost > MAXB));
  endtask

  task automatic fill(input int seed, input int n);
    for (int i = 0; i < n; i++) host_b[i] = 8'((seed * 37 + i * 29 + 5) & 8'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!fifo_wr_en && !burst_done && !burst_ovf, "R10 reset state",
        int'({fifo_wr_en, burst_done, burst_ovf}), 0);
    // R11: serial clock edges with select low
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    repeat (6) @(negedge clk);
    chk(ncap == 0, "R11 no write while select low", ncap, 0);
    // R1 R2 R3 R4 R5 sweep
    for (int lr = 0; lr < 8; lr++)
      for (int dh = 0; dh < 2; dh++)
        for (int se = 0; se < 2; se++) begin
          int len;
          len = (lr == 0) ? 1 : ((lr > 5) ? 5 : lr);
          cfg_dst_bank = {5{8'(lr * 16 + dh * 4 + se)}} ^ 40'hA1B2C3D4E5;
          cfg_src_bank = {5{8'(lr * 8 + 3)}} ^ 40'h5D4C3B2A19;
          fill(lr * 4 + dh * 2 + se, 16);
          run_burst(dh[0], 3'(lr), se[0], (dh != 0 ? len : 0) + 1 + lr % 3, 3, 1'b0,
                    dh != 0 ? "R2/R3/R4/R5 stream" : "R1/R3/R4/R5 stream");
        end
    // R6: seven trailing bits discarded
    fill(77, 8);
    run_burst(1'b0, 3'd2, 1'b1, 2, 7, 1'b0, "R6 partial tail dropped");
    // R7: exact limit and one byte over
    fill(91, 40);
    run_burst(1'b0, 3'd1, 1'b0, 37, 3, 1'b0, "R7 limit burst");
    run_burst(1'b0, 3'd1, 1'b0, 38, 3, 1'b0, "R7 over limit burst");
    // R9: config changed mid-burst
    cfg_dst_bank = 40'h0102030405; cfg_src_bank = 40'h1122334455;
    fill(13, 8);
    run_burst(1'b0, 3'd2, 1'b0, 3, 3, 1'b1, "R9 config snapshot");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule